// File: doc/BRIEF.md
# Sparse-Space Address Translator

This block turns a processor-side sparse-space access into a PCI-side access. The size and byte position of a sparse access are not carried on separate signals. They sit in low address bits just above the data granule. The block expands them into a four-bit active-low byte-enable field, forms the 32-bit PCI address, and moves write data into the byte lanes it addresses. When the bus returns read data, the block pulls the addressed bytes back down to bit 0 and zero-extends them.

The processor address is shifted down by five places, so the PCI longword address comes from the address bits above the offset field. Each of the three sparse regions keeps a different number of those bits: 29 for region 1, 27 for region 2 and 26 for region 3. A programmable extension register supplies the PCI address bits above the region's window. A request steps through five named states:

- `ST_IDLE`: ready for a request. Leaves for `ST_DECODE` when `req_valid` is high.
- `ST_DECODE`: one cycle spent forming the result. Always goes to `ST_ISSUE`.
- `ST_ISSUE`: the result is presented for one cycle. A legal read goes on to `ST_WAIT_DATA`. A write or an illegal access goes back to `ST_IDLE`.
- `ST_WAIT_DATA`: waits until `bus_rvalid` is high, then goes to `ST_RETURN`.
- `ST_RETURN`: presents the extracted read data for one cycle, then goes back to `ST_IDLE`.

Top module: `sparse_xlate`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) puts the block in `ST_IDLE`. After reset `req_ready`=1, `iss_valid`=0 and `cpu_rvalid`=0, and the extension register holds zero. A reset in the middle of a transaction ends that transaction.
- R2: A request is accepted on a clock edge where both `req_valid` and `req_ready` are high. `req_ready` is 0 in the cycle after acceptance. `iss_valid` is 1 for exactly one cycle, two cycles after acceptance. A write or an illegal access is followed by `req_ready`=1 in the next cycle.
- R3: Address bits 4:3 give the length: 00 byte, 01 word (2 bytes), 10 tribyte (3 bytes), 11 longword. Bits 6:5 give the byte lane. For byte, word and tribyte accesses, `pci_be_n` is 0 exactly on lanes lane to lane+length-1. For example, a byte at lane 2 gives 1011, a word at lane 1 gives 1001 and a tribyte at lane 1 gives 0001.
- R4: A longword must have the offset field equal to 10. It gives `pci_be_n`=0000 and uses lane 0 for data.
- R5: The access is flagged illegal (`iss_illegal`=1, `pci_be_n`=1111, `pci_addr`=0, `pci_wdata`=0) in any of these cases: the length/offset pair runs past lane 3; a longword has an offset other than 10; the region code is 0; address bit 39 is 0 (bit 39 set means uncached I/O space); any of address bits 2:0 or 38:37 is nonzero. An illegal read does not wait for bus data.
- R6: `pci_addr[1:0]` is 00. `pci_addr[k]` equals `req_addr[k+5]` for every k from 2 up to the top of the region window: k<29 in region 1, k<27 in region 2, k<26 in region 3.
- R7: Each `pci_addr` bit at or above the region's window width takes its value from the extension register. Extension bit i supplies `pci_addr` bit 26+i.
- R8: A write of `ext_wdata` when `ext_we`=1 loads the extension register at the clock edge.
- R9: For a legal write, `pci_wdata` equals `req_wdata` shifted left by 8 times the lane, keeping 32 bits. For a read, `pci_wdata` is 0.
- R10: For a legal read, the block holds in `ST_WAIT_DATA` with `cpu_rvalid`=0 for as long as `bus_rvalid` stays 0. The edge that samples `bus_rvalid`=1 leads to `cpu_rvalid`=1 for one cycle. During that cycle `cpu_rdata` is `bus_rdata` shifted right by 8 times the lane, with the bytes above the access length cleared. The block is idle in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and will accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_region | input | 2 | Sparse region select, 1 to 3 |
| req_addr | input | 40 | Processor sparse-space address |
| req_wdata | input | 32 | Write data, right-aligned |
| ext_we | input | 1 | Extension register write strobe |
| ext_wdata | input | 6 | Extension value for PCI bits 31:26 |
| iss_valid | output | 1 | Translated access presented |
| iss_illegal | output | 1 | Access encoding was illegal |
| iss_write | output | 1 | Presented access is a write |
| pci_addr | output | 32 | PCI bus address |
| pci_be_n | output | 4 | Active-low byte enables |
| pci_wdata | output | 32 | Lane-steered write data |
| bus_rvalid | input | 1 | Read data returned by the bus |
| bus_rdata | input | 32 | Returned read data, lane-aligned |
| cpu_rvalid | output | 1 | Extracted read data valid |
| cpu_rdata | output | 32 | Read data, right-aligned and zero-extended |

## Verification
The properties assume `req_valid` is only seen through the ready handshake, so a request held high while the block is busy has no effect. They also assume `bus_rvalid` means something only in the wait state. The stimulus raises `req_valid` for a single cycle while `req_ready` is high. It drives `bus_rvalid` only after a legal read has been issued, sometimes after a delay of several cycles. It changes the extension register only while the block is idle. The bench computes the expected address from the region window rule and the extension value it wrote, not from anything inside the design.

// File: rtl/sparse_xlate_pkg.sv
package sparse_xlate_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DECODE,
        ST_ISSUE,
        ST_WAIT_DATA,
        ST_RETURN
    } xl_state_e;

    typedef enum logic [1:0] {
        LEN_BYTE = 2'b00,
        LEN_WORD = 2'b01,
        LEN_TRI  = 2'b10,
        LEN_LONG = 2'b11
    } xfer_len_e;

    // Only offset code that a longword may use.
    localparam logic [1:0] LONG_OFF_CODE = 2'b10;

endpackage

// File: rtl/sparse_lane_decode.sv
module sparse_lane_decode
    import sparse_xlate_pkg::*;
#(
    parameter int BE_W = 4,
    localparam int OFF_W = $clog2(BE_W),
    localparam int CNT_W = OFF_W + 1
) (
    input  logic [1:0]       len_code,
    input  logic [OFF_W-1:0] off_code,
    output logic [BE_W-1:0]  be_n,
    output logic [OFF_W-1:0] lane,
    output logic [CNT_W-1:0] nbytes,
    output logic             legal
);

    always_comb begin
        nbytes = CNT_W'(len_code) + CNT_W'(1);
        if (len_code == LEN_LONG) begin
            // A longword always uses lane 0; its offset field must hold one fixed code.
            lane  = '0;
            legal = (off_code == OFF_W'(LONG_OFF_CODE));
        end else begin
            lane  = off_code;
            legal = ((int'(off_code) + int'(nbytes)) <= BE_W);
        end
        for (int i = 0; i < BE_W; i++) begin
            be_n[i] = !(legal && (i >= int'(lane)) &&
                        (i < (int'(lane) + int'(nbytes))));
        end
    end

endmodule

// File: rtl/sparse_addr_map.sv
module sparse_addr_map #(
    parameter int PCI_AW  = 32,
    parameter int R1_BITS = 29,
    parameter int R2_BITS = 27,
    parameter int R3_BITS = 26,
    localparam int EXT_W  = PCI_AW - R3_BITS,
    localparam int FLD_W  = PCI_AW - 2
) (
    input  logic [FLD_W-1:0]  lw_field,
    input  logic [1:0]        region,
    input  logic [EXT_W-1:0]  ext_bits,
    output logic [PCI_AW-1:0] pci_addr,
    output logic              region_ok
);

    logic [PCI_AW-1:0] win_mask [4];
    logic [PCI_AW-1:0] base;
    logic [PCI_AW-1:0] ext_full;
    logic [PCI_AW-1:0] sel_mask;

    // One window mask per region code; code 0 opens no window.
    for (genvar r = 0; r < 4; r++) begin : g_win
        if (r == 0) begin : g_none
            assign win_mask[r] = '0;
        end else begin : g_open
            localparam int RB = (r == 1) ? R1_BITS : (r == 2) ? R2_BITS : R3_BITS;
            assign win_mask[r] = {{(PCI_AW - RB){1'b0}}, {RB{1'b1}}};
        end
    end

    assign base      = {lw_field, 2'b00};
    assign ext_full  = {ext_bits, {R3_BITS{1'b0}}};
    assign sel_mask  = win_mask[region];
    assign pci_addr  = (ext_full & ~sel_mask) | (base & sel_mask);
    assign region_ok = (region != 2'd0);

endmodule

// File: rtl/sparse_lane_steer.sv
module sparse_lane_steer #(
    parameter int DW = 32,
    localparam int BE_W  = DW / 8,
    localparam int OFF_W = $clog2(BE_W),
    localparam int CNT_W = OFF_W + 1
) (
    input  logic [OFF_W-1:0] lane,
    input  logic [CNT_W-1:0] nbytes,
    input  logic [DW-1:0]    wdata,
    input  logic [DW-1:0]    bus_rdata,
    output logic [DW-1:0]    wr_lanes,
    output logic [DW-1:0]    rd_bytes
);

    for (genvar j = 0; j < BE_W; j++) begin : g_byte
        logic [7:0] wbyte;
        logic [7:0] rbyte;

        always_comb begin
            wbyte = 8'h00;
            if (j >= int'(lane)) begin
                wbyte = wdata[8*(j - int'(lane)) +: 8];
            end
        end

        always_comb begin
            rbyte = 8'h00;
            if ((j < int'(nbytes)) && ((j + int'(lane)) < BE_W)) begin
                rbyte = bus_rdata[8*(j + int'(lane)) +: 8];
            end
        end

        assign wr_lanes[8*j +: 8] = wbyte;
        assign rd_bytes[8*j +: 8] = rbyte;
    end

endmodule

// File: rtl/sparse_ext_reg.sv
module sparse_ext_reg #(
    parameter int EXT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [EXT_W-1:0] wdata,
    output logic [EXT_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            q <= wdata;
        end
    end

endmodule

// File: rtl/sparse_xlate.sv
module sparse_xlate
    import sparse_xlate_pkg::*;
#(
    parameter int CPU_AW  = 40,
    parameter int PCI_AW  = 32,
    parameter int DW      = 32,
    parameter int R1_BITS = 29,
    parameter int R2_BITS = 27,
    parameter int R3_BITS = 26,
    parameter int LEN_LSB = 3,
    localparam int BE_W    = DW / 8,
    localparam int OFF_W   = $clog2(BE_W),
    localparam int CNT_W   = OFF_W + 1,
    localparam int EXT_W   = PCI_AW - R3_BITS,
    localparam int FLD_W   = PCI_AW - 2,
    localparam int OFF_LSB = LEN_LSB + 2,
    localparam int FLD_LSB = OFF_LSB + OFF_W,
    localparam int FLD_MSB = FLD_LSB + FLD_W - 1,
    localparam int IO_BIT  = CPU_AW - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [1:0]        req_region,
    input  logic [CPU_AW-1:0] req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic              ext_we,
    input  logic [EXT_W-1:0]  ext_wdata,
    output logic              iss_valid,
    output logic              iss_illegal,
    output logic              iss_write,
    output logic [PCI_AW-1:0] pci_addr,
    output logic [BE_W-1:0]   pci_be_n,
    output logic [DW-1:0]     pci_wdata,
    input  logic              bus_rvalid,
    input  logic [DW-1:0]     bus_rdata,
    output logic              cpu_rvalid,
    output logic [DW-1:0]     cpu_rdata
);

    xl_state_e state_q, state_d;

    // Latched request
    logic             q_write;
    logic [1:0]       q_region;
    logic [1:0]       q_len;
    logic [OFF_W-1:0] q_off;
    logic [FLD_W-1:0] q_field;
    logic [DW-1:0]    q_wdata;
    logic             q_fmt_ok;

    // Issue-phase results
    logic              o_ill;
    logic              o_write;
    logic [PCI_AW-1:0] o_pci;
    logic [BE_W-1:0]   o_be_n;
    logic [DW-1:0]     o_wdata;
    logic [DW-1:0]     o_rdata;

    // Sub-block outputs
    logic [BE_W-1:0]   dec_be_n;
    logic [OFF_W-1:0]  dec_lane;
    logic [CNT_W-1:0]  dec_nbytes;
    logic              dec_legal;
    logic [PCI_AW-1:0] map_pci;
    logic              map_region_ok;
    logic [EXT_W-1:0]  ext_q;
    logic [DW-1:0]     st_wr_lanes;
    logic [DW-1:0]     st_rd_bytes;
    logic              fmt_ok_in;
    logic              access_ill;

    // Address format: I/O marker set, and bits that must be zero are zero.
    assign fmt_ok_in = req_addr[IO_BIT]
                     && (req_addr[LEN_LSB-1:0] == '0)
                     && (req_addr[IO_BIT-1:FLD_MSB+1] == '0);

    sparse_ext_reg #(.EXT_W(EXT_W)) u_ext (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ext_we),
        .wdata (ext_wdata),
        .q     (ext_q)
    );

    sparse_lane_decode #(.BE_W(BE_W)) u_dec (
        .len_code (q_len),
        .off_code (q_off),
        .be_n     (dec_be_n),
        .lane     (dec_lane),
        .nbytes   (dec_nbytes),
        .legal    (dec_legal)
    );

    sparse_addr_map #(
        .PCI_AW  (PCI_AW),
        .R1_BITS (R1_BITS),
        .R2_BITS (R2_BITS),
        .R3_BITS (R3_BITS)
    ) u_map (
        .lw_field  (q_field),
        .region    (q_region),
        .ext_bits  (ext_q),
        .pci_addr  (map_pci),
        .region_ok (map_region_ok)
    );

    sparse_lane_steer #(.DW(DW)) u_steer (
        .lane      (dec_lane),
        .nbytes    (dec_nbytes),
        .wdata     (q_wdata),
        .bus_rdata (bus_rdata),
        .wr_lanes  (st_wr_lanes),
        .rd_bytes  (st_rd_bytes)
    );

    assign access_ill = !(dec_legal && map_region_ok && q_fmt_ok);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid) state_d = ST_DECODE;
            ST_DECODE:    state_d = ST_ISSUE;
            ST_ISSUE:     state_d = (!o_write && !o_ill) ? ST_WAIT_DATA : ST_IDLE;
            ST_WAIT_DATA: if (bus_rvalid) state_d = ST_RETURN;
            ST_RETURN:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State-driven outputs
    always_comb begin
        req_ready  = 1'b0;
        iss_valid  = 1'b0;
        cpu_rvalid = 1'b0;
        unique case (state_q)
            ST_IDLE:      req_ready  = 1'b1;
            ST_DECODE:    ;
            ST_ISSUE:     iss_valid  = 1'b1;
            ST_WAIT_DATA: ;
            ST_RETURN:    cpu_rvalid = 1'b1;
            default:      ;
        endcase
    end

    // Request capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_write  <= 1'b0;
            q_region <= '0;
            q_len    <= '0;
            q_off    <= '0;
            q_field  <= '0;
            q_wdata  <= '0;
            q_fmt_ok <= 1'b0;
        end else if (state_q == ST_IDLE && req_valid) begin
            q_write  <= req_write;
            q_region <= req_region;
            q_len    <= req_addr[LEN_LSB +: 2];
            q_off    <= req_addr[OFF_LSB +: OFF_W];
            q_field  <= req_addr[FLD_MSB:FLD_LSB];
            q_wdata  <= req_wdata;
            q_fmt_ok <= fmt_ok_in;
        end
    end

    // Result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_ill   <= 1'b0;
            o_write <= 1'b0;
            o_pci   <= '0;
            o_be_n  <= '1;
            o_wdata <= '0;
            o_rdata <= '0;
        end else begin
            if (state_q == ST_DECODE) begin
                o_ill   <= access_ill;
                o_write <= q_write;
                o_pci   <= access_ill ? '0 : map_pci;
                o_be_n  <= access_ill ? '1 : dec_be_n;
                o_wdata <= (access_ill || !q_write) ? '0 : st_wr_lanes;
            end
            if (state_q == ST_WAIT_DATA && bus_rvalid) begin
                o_rdata <= st_rd_bytes;
            end
        end
    end

    assign iss_illegal = o_ill;
    assign iss_write   = o_write;
    assign pci_addr    = o_pci;
    assign pci_be_n    = o_be_n;
    assign pci_wdata   = o_wdata;
    assign cpu_rdata   = o_rdata;

endmodule

// File: rtl/sparse_xlate_chk.sv
module sparse_xlate_chk #(
    parameter int PCI_AW = 32,
    parameter int DW     = 32,
    parameter int BE_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              iss_valid,
    input logic              iss_illegal,
    input logic              iss_write,
    input logic [PCI_AW-1:0] pci_addr,
    input logic [BE_W-1:0]   pci_be_n,
    input logic [DW-1:0]     pci_wdata,
    input logic              cpu_rvalid
);

    assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_issue_two_later_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 iss_valid);

    assert_one_phase_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_ready, iss_valid, cpu_rvalid}));

    assert_write_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_write) |=> req_ready);

    assert_some_lane_on_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_illegal) |-> ($countones(pci_be_n) <= BE_W - 1));

    assert_illegal_no_lane_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_illegal) |-> (pci_be_n == '1 && pci_addr == '0));

    assert_illegal_back_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_illegal) |=> req_ready);

    assert_low_addr_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (pci_addr[1:0] == 2'b00));

    assert_read_no_wdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_write) |-> (pci_wdata == '0));

    assert_return_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |=> (req_ready && !cpu_rvalid));

endmodule

bind sparse_xlate sparse_xlate_chk #(.PCI_AW(PCI_AW), .DW(DW), .BE_W(BE_W)) u_chk (.*);

// File: tb/sparse_xlate_test.sv
`timescale 1ns/1ps
module sparse_xlate_test;

    typedef struct packed {
        logic [1:0]  rgn;
        logic        wr;
        logic [29:0] fld;
        logic [1:0]  len;
        logic [1:0]  off;
        logic [31:0] wd;
        logic [31:0] bus;
        logic [3:0]  be;
        logic        ill;
        logic [31:0] dat;
    } vec_t;

    // Expected values come from R3, R4, R5, R9 and R10.
    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{2'd1, 1'b1, 30'h0123456,  2'd0, 2'd0, 32'h000000AB, 32'h0,        4'hE, 1'b0, 32'h000000AB},
        '{2'd1, 1'b1, 30'h3ABCDEF1, 2'd0, 2'd3, 32'h000000CD, 32'h0,        4'h7, 1'b0, 32'hCD000000},
        '{2'd2, 1'b0, 30'h00FF00F,  2'd1, 2'd1, 32'h0,        32'h11223344, 4'h9, 1'b0, 32'h00002233},
        '{2'd3, 1'b1, 30'h2AAAAAA,  2'd1, 2'd2, 32'h0000BEEF, 32'h0,        4'h3, 1'b0, 32'hBEEF0000},
        '{2'd1, 1'b0, 30'h1000001,  2'd2, 2'd1, 32'h0,        32'hAABBCCDD, 4'h1, 1'b0, 32'h00AABBCC},
        '{2'd2, 1'b1, 30'h3FFFFFF,  2'd2, 2'd0, 32'h00123456, 32'h0,        4'h8, 1'b0, 32'h00123456},
        '{2'd3, 1'b0, 30'h0000010,  2'd3, 2'd2, 32'h0,        32'hDEADBEEF, 4'h0, 1'b0, 32'hDEADBEEF},
        '{2'd1, 1'b1, 30'h1234567,  2'd3, 2'd2, 32'hCAFEF00D, 32'h0,        4'h0, 1'b0, 32'hCAFEF00D},
        '{2'd1, 1'b1, 30'h0000100,  2'd1, 2'd3, 32'h00001234, 32'h0,        4'hF, 1'b1, 32'h0},
        '{2'd2, 1'b0, 30'h0000200,  2'd3, 2'd0, 32'h0,        32'h12345678, 4'hF, 1'b1, 32'h0},
        '{2'd3, 1'b1, 30'h0000300,  2'd2, 2'd2, 32'h00ABCDEF, 32'h0,        4'hF, 1'b1, 32'h0},
        '{2'd1, 1'b0, 30'h0000400,  2'd0, 2'd2, 32'h0,        32'h55667788, 4'hB, 1'b0, 32'h00000066},
        '{2'd0, 1'b1, 30'h0000500,  2'd0, 2'd0, 32'h00000011, 32'h0,        4'hF, 1'b1, 32'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [1:0]  req_region = 2'd0;
    logic [39:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        ext_we = 1'b0;
    logic [5:0]  ext_wdata = '0;
    logic        iss_valid;
    logic        iss_illegal;
    logic        iss_write;
    logic [31:0] pci_addr;
    logic [3:0]  pci_be_n;
    logic [31:0] pci_wdata;
    logic        bus_rvalid = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        cpu_rvalid;
    logic [31:0] cpu_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    sparse_xlate uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_region  (req_region),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .ext_we      (ext_we),
        .ext_wdata   (ext_wdata),
        .iss_valid   (iss_valid),
        .iss_illegal (iss_illegal),
        .iss_write   (iss_write),
        .pci_addr    (pci_addr),
        .pci_be_n    (pci_be_n),
        .pci_wdata   (pci_wdata),
        .bus_rvalid  (bus_rvalid),
        .bus_rdata   (bus_rdata),
        .cpu_rvalid  (cpu_rvalid),
        .cpu_rdata   (cpu_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [39:0] mk_addr(input logic [29:0] fld, input logic [1:0] len, input logic [1:0] off);
        return {1'b1, 2'b00, fld, off, len, 3'b000};
    endfunction

    // R6 and R7: window bits from the address, the rest from the extension value.
    function automatic logic [31:0] exp_pci(input logic [1:0] rgn, input logic [29:0] fld, input logic [5:0] ext);
        int bits;
        logic [31:0] m;
        bits = (rgn == 2'd1) ? 29 : (rgn == 2'd2) ? 27 : 26;
        m = (32'h1 << bits) - 32'h1;
        return ({ext, 26'b0} & ~m) | ({fld, 2'b00} & m);
    endfunction

    task automatic write_ext(input logic [5:0] v);
        @(negedge clk);
        ext_we = 1'b1;
        ext_wdata = v;
        @(negedge clk);
        ext_we = 1'b0;
    endtask

    task automatic do_access(input logic [1:0] rgn, input logic wr, input logic [39:0] addr,
                             input logic [31:0] wd, input logic [31:0] bus, input int waitc,
                             input logic [3:0] e_be, input logic e_ill, input logic [31:0] e_pci,
                             input logic [31:0] e_dat, input bit is_long);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_region = rgn;
        req_addr = addr;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2 busy after accept", {31'b0, req_ready}, 32'h0);
        @(negedge clk);
        chk(iss_valid == 1'b1, "R2 issue cycle", {31'b0, iss_valid}, 32'h1);
        chk(iss_illegal == e_ill, "R5 illegal flag", {31'b0, iss_illegal}, {31'b0, e_ill});
        if (is_long)
            chk(pci_be_n == e_be, "R4 longword enables", {28'b0, pci_be_n}, {28'b0, e_be});
        else
            chk(pci_be_n == e_be, "R3 byte enables", {28'b0, pci_be_n}, {28'b0, e_be});
        chk(pci_addr == e_pci, "R6 R7 pci address", pci_addr, e_pci);
        if (wr)
            chk(pci_wdata == e_dat, "R9 write lanes", pci_wdata, e_dat);
        else
            chk(pci_wdata == 32'h0, "R9 read has no write data", pci_wdata, 32'h0);
        if (!wr && !e_ill) begin
            @(negedge clk);
            for (int k = 0; k < waitc; k++) begin
                chk(cpu_rvalid == 1'b0 && req_ready == 1'b0, "R10 waiting for bus",
                    {31'b0, cpu_rvalid}, 32'h0);
                @(negedge clk);
            end
            bus_rvalid = 1'b1;
            bus_rdata = bus;
            @(negedge clk);
            bus_rvalid = 1'b0;
            bus_rdata = 32'h0;
            chk(cpu_rvalid == 1'b1, "R10 read return valid", {31'b0, cpu_rvalid}, 32'h1);
            chk(cpu_rdata == e_dat, "R10 read extract", cpu_rdata, e_dat);
            @(negedge clk);
            chk(req_ready == 1'b1 && cpu_rvalid == 1'b0, "R10 idle after return",
                {31'b0, req_ready}, 32'h1);
        end else begin
            @(negedge clk);
            chk(req_ready == 1'b1, "R2 idle after write or illegal", {31'b0, req_ready}, 32'h1);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [5:0] ext_val;
        logic [39:0] a;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1 && iss_valid == 1'b0 && cpu_rvalid == 1'b0, "R1 reset outputs",
            {29'b0, req_ready, iss_valid, cpu_rvalid}, 32'h4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready after reset", {31'b0, req_ready}, 32'h1);

        // R1 R8: extension register is zero after reset
        do_access(2'd1, 1'b1, mk_addr(30'h3FFFFFFF, 2'd3, 2'd2), 32'h01020304, 32'h0, 0,
                  4'h0, 1'b0, exp_pci(2'd1, 30'h3FFFFFFF, 6'h00), 32'h01020304, 1'b1);

        // R8: load extension, then walk the vector table
        ext_val = 6'h2D;
        write_ext(ext_val);
        for (int i = 0; i < NV; i++) begin
            do_access(VEC[i].rgn, VEC[i].wr, mk_addr(VEC[i].fld, VEC[i].len, VEC[i].off),
                      VEC[i].wd, VEC[i].bus, i % 3, VEC[i].be, VEC[i].ill,
                      VEC[i].ill ? 32'h0 : exp_pci(VEC[i].rgn, VEC[i].fld, ext_val),
                      VEC[i].dat, (VEC[i].len == 2'd3));
        end

        // R7 R8: all-ones extension in region 1 and region 3
        ext_val = 6'h3F;
        write_ext(ext_val);
        do_access(2'd1, 1'b0, mk_addr(30'h0, 2'd1, 2'd0), 32'h0, 32'hFFFF1234, 0,
                  4'hC, 1'b0, 32'hE0000000, 32'h00001234, 1'b0);
        do_access(2'd3, 1'b1, mk_addr(30'h0000001, 2'd0, 2'd1), 32'h000000EE, 32'h0, 0,
                  4'hD, 1'b0, 32'hFC000004, 32'h0000EE00, 1'b0);

        // R5: I/O marker clear
        a = mk_addr(30'h10, 2'd0, 2'd0);
        a[39] = 1'b0;
        do_access(2'd1, 1'b1, a, 32'h5, 32'h0, 0, 4'hF, 1'b1, 32'h0, 32'h0, 1'b0);
        // R5: upper must-be-zero bit set
        a = mk_addr(30'h10, 2'd0, 2'd0);
        a[38] = 1'b1;
        do_access(2'd2, 1'b0, a, 32'h0, 32'h0, 0, 4'hF, 1'b1, 32'h0, 32'h0, 1'b0);
        // R5: lowest must-be-zero bit set
        a = mk_addr(30'h10, 2'd0, 2'd0);
        a[0] = 1'b1;
        do_access(2'd3, 1'b1, a, 32'h5, 32'h0, 0, 4'hF, 1'b1, 32'h0, 32'h0, 1'b0);

        // R10: long wait for read data
        do_access(2'd2, 1'b0, mk_addr(30'h77, 2'd0, 2'd1), 32'h0, 32'h0000AB00, 7,
                  4'hD, 1'b0, exp_pci(2'd2, 30'h77, ext_val), 32'h000000AB, 1'b0);

        // R1: reset while waiting for read data, extension cleared
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_region = 2'd1;
        req_addr = mk_addr(30'h99, 2'd0, 2'd0);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && cpu_rvalid == 1'b0, "R1 reset mid-read",
            {30'b0, req_ready, cpu_rvalid}, 32'h2);
        rst_n = 1'b1;
        do_access(2'd1, 1'b1, mk_addr(30'h3FFFFFFF, 2'd0, 2'd0), 32'h7, 32'h0, 0,
                  4'hE, 1'b0, exp_pci(2'd1, 30'h3FFFFFFF, 6'h00), 32'h7, 1'b0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule